// File: doc/BRIEF.md
# Serial Configuration Byte Receiver

This block listens on one asynchronous serial line and turns single-byte commands into seven volatile configuration flags for the rest of a display pipeline. Characters use 8N1 framing, least significant bit first, at a baud rate derived from a clock-frequency parameter (115200 baud by default). Each character is a complete command. Bit 7 is an integrity bit that must equal the XOR of bits 6:0. A character that passes the check replaces all seven flags at once. A character that fails the check is dropped and reported on a one-cycle error strobe.

The block also watches how long the line stays idle-high. If the line is held high with no new character for longer than a programmable time (five seconds by default), it raises a debug-entry request. The request stays up for as long as the line stays high. It drops as soon as a start bit pulls the line low. Apart from that, a line held low or left at a constant level keeps the flags last committed. After reset the flags are all zero, which is the default configuration.

Top module: `serial_flag_port`

## Requirements
- R1: During and after reset `cfg_flags` is 7'h00, and `byte_ok`, `csum_err` and `dbg_req` are low.
- R2: A character received as 8N1, LSB first, at CLK_HZ/BAUD clocks per bit, whose bit 7 equals the XOR of bits 6:0, is loaded into `cfg_flags` as bits 6:0. It produces exactly one single-cycle `byte_ok` pulse, and the flags change in no other cycle. Flag positions: 0 deep-colour select, 1 alternate lane mapping, 2 debug enable, 3 overlay enable, 4 crosshair enable, 5 LED strings off, 6 update enable.
- R3: A character whose bit 7 differs from the XOR of bits 6:0 produces exactly one `csum_err` pulse, no `byte_ok` pulse, and leaves `cfg_flags` unchanged. `byte_ok` and `csum_err` are never high together.
- R4: A character whose stop bit is sampled low is discarded: no strobe, and `cfg_flags` unchanged.
- R5: A low pulse that is no longer low at the middle of the start bit (shorter than half a bit) is ignored: no strobe, and `cfg_flags` unchanged.
- R6: A line held low for many bit times (a break) leaves `cfg_flags` at its last committed value and produces no strobe.
- R7: With IDLE_LIMIT = (CLK_HZ/1000)*IDLE_MS, `dbg_req` is high in each cycle in which the synchronized line has been high for more than IDLE_LIMIT consecutive samples. With the default two-stage synchronizer, an input high across exactly IDLE_LIMIT clock edges never raises it. One more edge raises it for one cycle, and it stays low while the synchronized line is low.
- R8: A start bit ends a pending `dbg_req`, restarts the idle timer, and the character it begins is received normally.
- R9: Characters sent back to back with no idle time between them are each received, and the last accepted one defines all seven flags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| uart_rx | input | 1 | Asynchronous serial line, idle high |
| cfg_flags | output | 7 | Committed configuration flags |
| byte_ok | output | 1 | One-cycle pulse when a character is committed |
| csum_err | output | 1 | One-cycle pulse when a character fails the integrity check |
| dbg_req | output | 1 | High while the line has been idle-high beyond the timeout |

## Verification
The idle timer reaching its limit and a start bit arriving can land in the same cycle. A start bit is then both the event that ends the idle period and the first bit of a real command. The bench holds the line high for exactly IDLE_LIMIT edges before a start bit, and again for IDLE_LIMIT plus one edges. It counts the cycles in which `dbg_req` is high: none in the first case, exactly one in the second. It also confirms that the character beginning with that very start bit is committed in both cases.

// File: rtl/sfp_pkg.sv
package sfp_pkg;
  localparam int BYTE_W = 8;
  localparam int FLAG_W = BYTE_W - 1;

  typedef enum logic [1:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_STOP
  } rx_state_e;

  // Integrity rule: top bit equals XOR of the flag bits.
  function automatic logic csum_ok(input logic [BYTE_W-1:0] b);
    return b[BYTE_W-1] == (^b[FLAG_W-1:0]);
  endfunction
endpackage

// File: rtl/sfp_sync.sv
module sfp_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] pipe;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) pipe <= '1;
        else     pipe <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) pipe <= '1;
        else     pipe <= {pipe[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/sfp_uart_rx.sv
module sfp_uart_rx
  import sfp_pkg::*;
#(
  parameter int CLKS_PER_BIT = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_s,
  output logic              frame_vld,
  output logic [BYTE_W-1:0] frame_data
);
  localparam int CW = (CLKS_PER_BIT > 2) ? $clog2(CLKS_PER_BIT) : 1;
  localparam int IW = $clog2(BYTE_W);
  localparam logic [CW-1:0] LAST = CW'(CLKS_PER_BIT - 1);
  localparam logic [CW-1:0] MID  = CW'(CLKS_PER_BIT / 2 - 1);
  localparam logic [IW-1:0] TOP  = IW'(BYTE_W - 1);

  rx_state_e         state;
  logic [CW-1:0]     cnt;
  logic [IW-1:0]     idx;
  logic [BYTE_W-1:0] shreg;
  logic              rx_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= RX_IDLE;
      cnt       <= '0;
      idx       <= '0;
      shreg     <= '0;
      rx_prev   <= 1'b1;
      frame_vld <= 1'b0;
    end else begin
      frame_vld <= 1'b0;
      rx_prev   <= rx_s;
      unique case (state)
        RX_IDLE: begin
          // only a falling edge starts a character, so a held-low line stays idle (R6)
          if (rx_prev && !rx_s) begin
            state <= RX_START;
            cnt   <= '0;
          end
        end
        RX_START: begin
          if (cnt == MID) begin
            cnt <= '0;
            idx <= '0;
            // R5: a start bit already gone at mid-bit is a glitch
            state <= rx_s ? RX_IDLE : RX_DATA;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        RX_DATA: begin
          if (cnt == LAST) begin
            cnt   <= '0;
            shreg <= {rx_s, shreg[BYTE_W-1:1]};
            if (idx == TOP) state <= RX_STOP;
            else            idx   <= idx + 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        RX_STOP: begin
          if (cnt == LAST) begin
            cnt       <= '0;
            state     <= RX_IDLE;
            // R4: a low stop bit discards the character
            frame_vld <= rx_s;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= RX_IDLE;
      endcase
    end
  end

  assign frame_data = shreg;
endmodule

// File: rtl/sfp_idle_watch.sv
module sfp_idle_watch #(
  parameter int IDLE_LIMIT = 1600
) (
  input  logic clk,
  input  logic rst,
  input  logic rx_s,
  output logic dbg_req
);
  localparam int CW = $clog2(IDLE_LIMIT + 1);
  localparam logic [CW-1:0] LIM = CW'(IDLE_LIMIT);

  logic [CW-1:0] run_len;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_len <= '0;
      dbg_req <= 1'b0;
    end else begin
      // low samples (start bits included) restart the run; high samples extend it
      if (!rx_s)             run_len <= '0;
      else if (run_len != LIM) run_len <= run_len + 1'b1;
      dbg_req <= rx_s && (run_len == LIM);
    end
  end
endmodule

// File: rtl/sfp_flag_reg.sv
module sfp_flag_reg
  import sfp_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_vld,
  input  logic [BYTE_W-1:0] frame_data,
  output logic [FLAG_W-1:0] flags,
  output logic              byte_ok,
  output logic              csum_err
);
  logic good;
  assign good = csum_ok(frame_data);

  always_ff @(posedge clk) begin
    if (rst) begin
      flags    <= '0;
      byte_ok  <= 1'b0;
      csum_err <= 1'b0;
    end else begin
      byte_ok  <= frame_vld && good;
      csum_err <= frame_vld && !good;
      if (frame_vld && good) flags <= frame_data[FLAG_W-1:0];
    end
  end
endmodule

// File: rtl/serial_flag_port.sv
module serial_flag_port
  import sfp_pkg::*;
#(
  parameter int CLK_HZ      = 100_000_000,
  parameter int BAUD        = 115_200,
  parameter int IDLE_MS     = 5000,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              uart_rx,
  output logic [FLAG_W-1:0] cfg_flags,
  output logic              byte_ok,
  output logic              csum_err,
  output logic              dbg_req
);
  localparam int CLKS_PER_BIT = CLK_HZ / BAUD;
  localparam int IDLE_LIMIT   = (CLK_HZ / 1000) * IDLE_MS;

  logic              rx_sync;
  logic              frame_vld;
  logic [BYTE_W-1:0] frame_data;

  sfp_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (uart_rx),
    .q   (rx_sync)
  );

  sfp_uart_rx #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_rx (
    .clk        (clk),
    .rst        (rst),
    .rx_s       (rx_sync),
    .frame_vld  (frame_vld),
    .frame_data (frame_data)
  );

  sfp_idle_watch #(.IDLE_LIMIT(IDLE_LIMIT)) u_idle (
    .clk     (clk),
    .rst     (rst),
    .rx_s    (rx_sync),
    .dbg_req (dbg_req)
  );

  sfp_flag_reg u_flags (
    .clk        (clk),
    .rst        (rst),
    .frame_vld  (frame_vld),
    .frame_data (frame_data),
    .flags      (cfg_flags),
    .byte_ok    (byte_ok),
    .csum_err   (csum_err)
  );
endmodule

// File: rtl/serial_flag_port_chk.sv
module serial_flag_port_chk (
  input logic       clk,
  input logic       rst,
  input logic       rx_s,
  input logic [6:0] cfg_flags,
  input logic       byte_ok,
  input logic       csum_err,
  input logic       dbg_req
);
  // R2
  flags_only_on_accept_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(cfg_flags) |-> byte_ok);

  // R2
  accept_single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    byte_ok |=> !byte_ok);

  // R3
  strobe_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    !(byte_ok && csum_err));

  // R3
  csum_keeps_flags_chk: assert property (@(posedge clk) disable iff (rst)
    csum_err |-> $stable(cfg_flags));

  // R7
  dbg_needs_high_line_chk: assert property (@(posedge clk) disable iff (rst)
    !rx_s |=> !dbg_req);
endmodule

bind serial_flag_port serial_flag_port_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .rx_s      (rx_sync),
  .cfg_flags (cfg_flags),
  .byte_ok   (byte_ok),
  .csum_err  (csum_err),
  .dbg_req   (dbg_req)
);

// File: tb/serial_flag_port_tb.sv
module serial_flag_port_tb;
  localparam int CLK_HZ  = 1_600_000;
  localparam int BAUD    = 100_000;
  localparam int IDLE_MS = 1;
  localparam int CPB     = CLK_HZ / BAUD;
  localparam int LIMIT   = (CLK_HZ / 1000) * IDLE_MS;

  // {expected accepted, byte}
  localparam logic [8:0] VEC [10] = '{9'h100, 9'h181, 9'h103, 9'h085, 9'h1FF,
                                      9'h07F, 9'h1AA, 9'h155, 9'h1C0, 9'h098};

  logic clk = 1'b0;
  logic rst;
  logic uart_rx;
  logic [6:0] cfg_flags;
  logic byte_ok, csum_err, dbg_req;

  int checks = 0;
  int errors = 0;
  int n_ok = 0, n_err = 0, n_dbg = 0;
  bit done = 0;

  always #5 clk = ~clk;

  serial_flag_port #(.CLK_HZ(CLK_HZ), .BAUD(BAUD), .IDLE_MS(IDLE_MS)) u_dut (
    .clk(clk), .rst(rst), .uart_rx(uart_rx), .cfg_flags(cfg_flags),
    .byte_ok(byte_ok), .csum_err(csum_err), .dbg_req(dbg_req));

  always @(negedge clk) begin
    if (!rst) begin
      if (byte_ok)  n_ok++;
      if (csum_err) n_err++;
      if (dbg_req)  n_dbg++;
    end
  end

  task automatic check(input bit cond, input string tag, input int act, input int exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // entered and left at a falling clock edge
  task automatic send_byte(input logic [7:0] b, input logic stop_v);
    uart_rx = 1'b0;
    idle(CPB);
    for (int i = 0; i < 8; i++) begin
      uart_rx = b[i];
      idle(CPB);
    end
    uart_rx = stop_v;
    idle(CPB);
    uart_rx = 1'b1;
  endtask

  task automatic hold_low(input int n);
    uart_rx = 1'b0;
    idle(n);
  endtask

  initial begin
    repeat (100_000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog all actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [6:0] exp_flags;
    int ok0, err0, dbg0;
    uart_rx = 1'b1;
    rst = 1'b1;
    idle(5);
    check(cfg_flags == 7'h00, "R1 flags in reset", cfg_flags, 0);
    rst = 1'b0;
    idle(1);
    check(cfg_flags == 7'h00, "R1 flags after reset", cfg_flags, 0);
    check(!byte_ok && !csum_err, "R1 strobes after reset", {byte_ok, csum_err}, 0);
    check(!dbg_req, "R1 dbg_req after reset", dbg_req, 0);
    exp_flags = 7'h00;

    // table walk: R2 accepted bytes, R3 rejected bytes
    foreach (VEC[k]) begin
      ok0 = n_ok; err0 = n_err;
      send_byte(VEC[k][7:0], 1'b1);
      idle(2 * CPB);
      if (VEC[k][8]) begin
        exp_flags = VEC[k][6:0];
        check(cfg_flags == exp_flags, "R2 flags load", cfg_flags, exp_flags);
        check(n_ok == ok0 + 1, "R2 one byte_ok", n_ok - ok0, 1);
        check(n_err == err0, "R2 no csum_err", n_err - err0, 0);
      end else begin
        check(cfg_flags == exp_flags, "R3 flags kept", cfg_flags, exp_flags);
        check(n_ok == ok0, "R3 no byte_ok", n_ok - ok0, 0);
        check(n_err == err0 + 1, "R3 one csum_err", n_err - err0, 1);
      end
    end

    // R9 back-to-back characters
    ok0 = n_ok;
    send_byte(8'h03, 1'b1);
    send_byte(8'hAA, 1'b1);
    idle(2 * CPB);
    check(n_ok == ok0 + 2, "R9 two accepts", n_ok - ok0, 2);
    check(cfg_flags == 7'h2A, "R9 last wins", cfg_flags, 7'h2A);

    // R4 low stop bit
    ok0 = n_ok; err0 = n_err;
    send_byte(8'h81, 1'b0);
    idle(2 * CPB);
    check(cfg_flags == 7'h2A, "R4 flags kept", cfg_flags, 7'h2A);
    check(n_ok == ok0 && n_err == err0, "R4 no strobe", (n_ok - ok0) + (n_err - err0), 0);

    // R5 short glitch
    hold_low(CPB / 4);
    uart_rx = 1'b1;
    idle(2 * CPB);
    check(cfg_flags == 7'h2A, "R5 flags kept", cfg_flags, 7'h2A);
    check(n_ok == ok0 && n_err == err0, "R5 no strobe", (n_ok - ok0) + (n_err - err0), 0);

    // R6 break
    hold_low(20 * CPB);
    check(cfg_flags == 7'h2A, "R6 flags kept", cfg_flags, 7'h2A);
    check(n_ok == ok0 && n_err == err0, "R6 no strobe", (n_ok - ok0) + (n_err - err0), 0);
    check(n_dbg == 0, "R7 no request so far", n_dbg, 0);

    // R7/R8: high for exactly LIMIT edges, then a start bit
    dbg0 = n_dbg; ok0 = n_ok;
    uart_rx = 1'b1;
    idle(LIMIT);
    send_byte(8'hC0, 1'b1);
    idle(2 * CPB);
    check(n_dbg == dbg0, "R7 limit edges no request", n_dbg - dbg0, 0);
    check(cfg_flags == 7'h40 && n_ok == ok0 + 1, "R8 byte after idle", cfg_flags, 7'h40);

    // R7/R8: one edge more gives a single request cycle
    hold_low(12 * CPB);
    dbg0 = n_dbg; ok0 = n_ok;
    uart_rx = 1'b1;
    idle(LIMIT + 1);
    send_byte(8'h81, 1'b1);
    idle(2 * CPB);
    check(n_dbg == dbg0 + 1, "R7 limit+1 edges one request", n_dbg - dbg0, 1);
    check(cfg_flags == 7'h01 && n_ok == ok0 + 1, "R8 start bit at expiry", cfg_flags, 7'h01);

    // R7 level request, R8 cleared by start bit
    hold_low(12 * CPB);
    uart_rx = 1'b1;
    idle(LIMIT + 20);
    check(dbg_req == 1'b1, "R7 request held", dbg_req, 1);
    send_byte(8'hFF, 1'b1);
    check(dbg_req == 1'b0, "R8 request cleared", dbg_req, 0);
    idle(2 * CPB);
    check(cfg_flags == 7'h7F, "R8 byte after request", cfg_flags, 7'h7F);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule